// File: doc/BRIEF.md
# Bus-Matching Width Converter with Byte Order Select

This block sits between a 36-bit long-word data path on the storage side and an external port whose width is 36, 18 or 9 bits. Outbound, it takes one long-word from the storage side and hands it to the port as one, two or four narrow units on successive enabled reads. Inbound, it collects one, two or four narrow writes into a long-word and then pushes that long-word to the storage side. Both directions share one clock. The storage side of each direction uses a valid/ready handshake.

Width and byte order come from three configuration pins: a bus-match pin, a size pin and a byte-order pin. The block samples them on every clock edge while master reset is held low and then keeps them fixed. One order rule covers both directions. In big-endian order the most significant part of a long-word travels first. In little-endian order the least significant part travels first.

A synchronous flush input empties both directions and keeps the latched configuration. Master reset clears all state and sets up a new configuration.

Top module: `bus_width_conv`

## Requirements
- R1: While `rst_ni` is low, each rising clock edge latches the width. `bus_match_i`=0 selects 36-bit mode with 1 unit per long-word. `bus_match_i`=1 with `size_i`=0 selects 18-bit mode with 2 units. `bus_match_i`=1 with `size_i`=1 selects 9-bit mode with 4 units.
- R2: In big-endian mode (`big_end_i`=1 latched at reset), the outbound units leave in order from most to least significant. In 18-bit mode that is bits [35:18], then [17:0]. In 9-bit mode it is [35:27], [26:18], [17:9], then [8:0].
- R3: In little-endian mode, the outbound units leave in order from least to most significant: bits [17:0] first in 18-bit mode, bits [8:0] first in 9-bit mode.
- R4: A narrow unit appears on the low bits of `port_rd_data_o`, and the bits above the unit width read zero. `port_rd_data_o` is all zeroes whenever `port_rd_valid_o` is low, including after either reset.
- R5: `fifo_rd_ready_o` is high only in two cases: the converter holds no long-word, or the last unit of the held long-word is being read in the same cycle. A long-word taken this way is presented on the next cycle.
- R6: In big-endian mode, the first inbound unit fills the most significant slot of the assembled long-word.
- R7: In little-endian mode, the first inbound unit fills the least significant slot of the assembled long-word.
- R8: `fifo_wr_valid_o` rises only on the cycle after the last of the 1, 2 or 4 units has been accepted. It then holds steady, with stable `fifo_wr_data_o`, until `fifo_wr_ready_i` is high. `port_wr_ready_o` is high when no long-word is pending or when the pending long-word is being taken.
- R9: When `flush_ni` is low at a clock edge, the held outbound long-word, the partial inbound assembly and any pending inbound long-word are all discarded, so both valid outputs are low on the next cycle. The latched width and byte order are kept.
- R10: Several inputs have no effect. A port read while `port_rd_valid_o` is low changes nothing. A port write while `port_wr_ready_o` is low changes nothing. Bits of `port_wr_data_i` above the unit width are ignored.
- R11: Changing `bus_match_i`, `size_i` or `big_end_i` while `rst_ni` is high has no effect on width or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low; configuration latched while low |
| flush_ni | input | 1 | Synchronous flush, active low; keeps configuration |
| bus_match_i | input | 1 | Narrow-port enable pin (0: 36-bit) |
| size_i | input | 1 | With bus match: 1 = 9-bit, 0 = 18-bit |
| big_end_i | input | 1 | Byte order select, 1 = big-endian |
| fifo_rd_data_i | input | 36 | Long-word offered by the storage side |
| fifo_rd_valid_i | input | 1 | Long-word offered |
| fifo_rd_ready_o | output | 1 | Long-word taken this cycle when valid |
| port_rd_en_i | input | 1 | Port read enable |
| port_rd_valid_o | output | 1 | A unit is present on the port |
| port_rd_data_o | output | 36 | Current outbound unit, zero-padded |
| port_wr_en_i | input | 1 | Port write enable |
| port_wr_data_i | input | 36 | Inbound unit on the low bits |
| port_wr_ready_o | output | 1 | Port write accepted this cycle when enabled |
| fifo_wr_valid_o | output | 1 | Assembled long-word pending |
| fifo_wr_data_o | output | 36 | Assembled long-word |
| fifo_wr_ready_i | input | 1 | Storage side takes the pending long-word |

## Verification
A wrong unit index, a slot index or a mode/order flop shows up at the port on the first read or push that follows. The symptom is a swapped or repeated slice on `port_rd_data_o`, or a long-word with its parts in the wrong slots on `fifo_wr_data_o`. A wrong count of units shows up within one long-word as an early or late `fifo_rd_ready_o` or `fifo_wr_valid_o`. The bench runs every width in both byte orders. In every cycle it compares each output against a queue model, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } bw_mode_e;

  function automatic logic [2:0] unit_count(bw_mode_e m);
    case (m)
      MODE_WORD: return 3'd2;
      MODE_BYTE: return 3'd4;
      default:   return 3'd1;
    endcase
  endfunction

  // slot holding the idx-th transferred unit
  function automatic logic [1:0] slot_of(logic [1:0] idx, bw_mode_e m, logic big);
    logic [2:0] t;
    t = unit_count(m) - 3'd1 - {1'b0, idx};
    return big ? t[1:0] : idx;
  endfunction

  function automatic int unsigned slot_shift(bw_mode_e m, logic [1:0] slot, int unsigned uw);
    case (m)
      MODE_WORD: return int'(slot) * 2 * uw;
      MODE_BYTE: return int'(slot) * uw;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/bwc_cfg.sv
module bwc_cfg
  import bwc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bus_match_i,
  input  logic     size_i,
  input  logic     big_end_i,
  output bw_mode_e mode_o,
  output logic     big_o
);

  bw_mode_e mode_q;
  logic     big_q;

  // sampled on every edge while master reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= !bus_match_i ? MODE_LONG : (size_i ? MODE_BYTE : MODE_WORD);
      big_q  <= big_end_i;
    end
  end

  assign mode_o = mode_q;
  assign big_o  = big_q;

endmodule

// File: rtl/bwc_unpack.sv
module bwc_unpack
  import bwc_pkg::*;
#(
  parameter int unsigned UNIT_W = 9,
  localparam int unsigned LW_W  = 4 * UNIT_W,
  localparam int unsigned SH_W  = $clog2(LW_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_ni,
  input  bw_mode_e        mode_i,
  input  logic            big_i,
  input  logic [LW_W-1:0] lw_data_i,
  input  logic            lw_valid_i,
  output logic            lw_ready_o,
  input  logic            take_i,
  output logic            nar_valid_o,
  output logic [LW_W-1:0] nar_data_o
);

  localparam logic [LW_W-1:0] M_BYTE = {{(LW_W-UNIT_W){1'b0}}, {UNIT_W{1'b1}}};
  localparam logic [LW_W-1:0] M_WORD = {{(LW_W-2*UNIT_W){1'b0}}, {(2*UNIT_W){1'b1}}};

  logic [LW_W-1:0] hold_q;
  logic            have_q;
  logic [1:0]      idx_q;
  logic            fire, last, load;
  logic [SH_W-1:0] sh;
  logic [LW_W-1:0] mask;

  assign last       = ({1'b0, idx_q} == unit_count(mode_i) - 3'd1);
  assign fire       = take_i && have_q;
  assign lw_ready_o = !have_q || (fire && last);
  assign load       = lw_valid_i && lw_ready_o;

  always_comb begin
    sh = SH_W'(slot_shift(mode_i, slot_of(idx_q, mode_i, big_i), UNIT_W));
    case (mode_i)
      MODE_WORD: mask = M_WORD;
      MODE_BYTE: mask = M_BYTE;
      default:   mask = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (!flush_ni) begin
      hold_q <= '0;
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      hold_q <= lw_data_i;
      have_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire && last) begin
      hold_q <= '0;
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (fire) begin
      idx_q  <= idx_q + 2'd1;
    end
  end

  assign nar_valid_o = have_q;
  assign nar_data_o  = have_q ? ((hold_q >> sh) & mask) : '0;

endmodule

// File: rtl/bwc_pack.sv
module bwc_pack
  import bwc_pkg::*;
#(
  parameter int unsigned UNIT_W = 9,
  localparam int unsigned LW_W  = 4 * UNIT_W,
  localparam int unsigned SH_W  = $clog2(LW_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_ni,
  input  bw_mode_e        mode_i,
  input  logic            big_i,
  input  logic            put_i,
  input  logic [LW_W-1:0] nar_data_i,
  output logic            put_ready_o,
  output logic            lw_valid_o,
  output logic [LW_W-1:0] lw_data_o,
  input  logic            lw_ready_i
);

  localparam logic [LW_W-1:0] M_BYTE = {{(LW_W-UNIT_W){1'b0}}, {UNIT_W{1'b1}}};
  localparam logic [LW_W-1:0] M_WORD = {{(LW_W-2*UNIT_W){1'b0}}, {(2*UNIT_W){1'b1}}};

  logic [LW_W-1:0] acc_q, pkt_q, merged, mask;
  logic [1:0]      cnt_q;
  logic            full_q, accept, last, pop;
  logic [SH_W-1:0] sh;

  assign put_ready_o = !full_q || lw_ready_i;
  assign accept      = put_i && put_ready_o;
  assign pop         = full_q && lw_ready_i;
  assign last        = ({1'b0, cnt_q} == unit_count(mode_i) - 3'd1);

  always_comb begin
    sh = SH_W'(slot_shift(mode_i, slot_of(cnt_q, mode_i, big_i), UNIT_W));
    case (mode_i)
      MODE_WORD: mask = M_WORD;
      MODE_BYTE: mask = M_BYTE;
      default:   mask = '1;
    endcase
    merged = acc_q | ((nar_data_i & mask) << sh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pkt_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (!flush_ni) begin
      acc_q  <= '0;
      pkt_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (pop) full_q <= 1'b0;
      if (accept && last) begin
        pkt_q  <= merged;
        full_q <= 1'b1;
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (accept) begin
        acc_q  <= merged;
        cnt_q  <= cnt_q + 2'd1;
      end
    end
  end

  assign lw_valid_o = full_q;
  assign lw_data_o  = pkt_q;

endmodule

// File: rtl/bus_width_conv.sv
module bus_width_conv
  import bwc_pkg::*;
#(
  parameter int unsigned UNIT_W = 9,
  localparam int unsigned LW_W  = 4 * UNIT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_ni,
  input  logic            bus_match_i,
  input  logic            size_i,
  input  logic            big_end_i,
  input  logic [LW_W-1:0] fifo_rd_data_i,
  input  logic            fifo_rd_valid_i,
  output logic            fifo_rd_ready_o,
  input  logic            port_rd_en_i,
  output logic            port_rd_valid_o,
  output logic [LW_W-1:0] port_rd_data_o,
  input  logic            port_wr_en_i,
  input  logic [LW_W-1:0] port_wr_data_i,
  output logic            port_wr_ready_o,
  output logic            fifo_wr_valid_o,
  output logic [LW_W-1:0] fifo_wr_data_o,
  input  logic            fifo_wr_ready_i
);

  bw_mode_e cfg_mode;
  logic     cfg_big;

  bwc_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_match_i (bus_match_i),
    .size_i      (size_i),
    .big_end_i   (big_end_i),
    .mode_o      (cfg_mode),
    .big_o       (cfg_big)
  );

  bwc_unpack #(.UNIT_W(UNIT_W)) i_unpack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_ni    (flush_ni),
    .mode_i      (cfg_mode),
    .big_i       (cfg_big),
    .lw_data_i   (fifo_rd_data_i),
    .lw_valid_i  (fifo_rd_valid_i),
    .lw_ready_o  (fifo_rd_ready_o),
    .take_i      (port_rd_en_i),
    .nar_valid_o (port_rd_valid_o),
    .nar_data_o  (port_rd_data_o)
  );

  bwc_pack #(.UNIT_W(UNIT_W)) i_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_ni    (flush_ni),
    .mode_i      (cfg_mode),
    .big_i       (cfg_big),
    .put_i       (port_wr_en_i),
    .nar_data_i  (port_wr_data_i),
    .put_ready_o (port_wr_ready_o),
    .lw_valid_o  (fifo_wr_valid_o),
    .lw_data_o   (fifo_wr_data_o),
    .lw_ready_i  (fifo_wr_ready_i)
  );

endmodule

// File: rtl/bwc_chk.sv
module bwc_chk
  import bwc_pkg::*;
#(
  parameter int unsigned UNIT_W = 9,
  localparam int unsigned LW_W  = 4 * UNIT_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flush_ni,
  input bw_mode_e        mode_i,
  input logic            fifo_rd_ready_o,
  input logic            port_rd_en_i,
  input logic            port_rd_valid_o,
  input logic [LW_W-1:0] port_rd_data_o,
  input logic            port_wr_en_i,
  input logic            port_wr_ready_o,
  input logic            fifo_wr_valid_o,
  input logic [LW_W-1:0] fifo_wr_data_o,
  input logic            fifo_wr_ready_i
);

  // R4
  word_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_WORD) |-> (port_rd_data_o[LW_W-1:2*UNIT_W] == '0));

  // R4
  byte_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYTE) |-> (port_rd_data_o[LW_W-1:UNIT_W] == '0));

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_rd_valid_o |-> (port_rd_data_o == '0));

  // R5
  rd_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_ready_o && port_rd_valid_o) |-> port_rd_en_i);

  // R10
  unit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_valid_o && !port_rd_en_i && flush_ni) |=> (port_rd_valid_o && $stable(port_rd_data_o)));

  // R8
  push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_valid_o && !fifo_wr_ready_i && flush_ni) |=> (fifo_wr_valid_o && $stable(fifo_wr_data_o)));

  // R8
  long_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LONG && port_wr_en_i && port_wr_ready_o && flush_ni) |=> fifo_wr_valid_o);

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_ni |=> (!port_rd_valid_o && !fifo_wr_valid_o));

endmodule

bind bus_width_conv bwc_chk #(.UNIT_W(UNIT_W)) i_bwc_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_ni        (flush_ni),
  .mode_i          (cfg_mode),
  .fifo_rd_ready_o (fifo_rd_ready_o),
  .port_rd_en_i    (port_rd_en_i),
  .port_rd_valid_o (port_rd_valid_o),
  .port_rd_data_o  (port_rd_data_o),
  .port_wr_en_i    (port_wr_en_i),
  .port_wr_ready_o (port_wr_ready_o),
  .fifo_wr_valid_o (fifo_wr_valid_o),
  .fifo_wr_data_o  (fifo_wr_data_o),
  .fifo_wr_ready_i (fifo_wr_ready_i)
);

// File: tb/test_bus_width_conv.sv
module test_bus_width_conv;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 36;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          flush_ni = 1'b1;
  logic          bus_match_i = 1'b0, size_i = 1'b0, big_end_i = 1'b0;
  logic [LW-1:0] fifo_rd_data_i = '0;
  logic          fifo_rd_valid_i = 1'b0;
  logic          fifo_rd_ready_o;
  logic          port_rd_en_i = 1'b0;
  logic          port_rd_valid_o;
  logic [LW-1:0] port_rd_data_o;
  logic          port_wr_en_i = 1'b0;
  logic [LW-1:0] port_wr_data_i = '0;
  logic          port_wr_ready_o;
  logic          fifo_wr_valid_o;
  logic [LW-1:0] fifo_wr_data_o;
  logic          fifo_wr_ready_i = 1'b0;

  bus_width_conv i_bus_width_conv (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int compared = 0, mismatched = 0;
  string phase = "R1 R11";

  // reference model state
  int            m_n = 1, m_uw = 36;
  bit            m_big = 1'b0;
  logic [LW-1:0] oq[$];
  logic [LW-1:0] iq[$];
  bit            pend = 1'b0;
  logic [LW-1:0] pword = '0;

  function automatic logic [LW-1:0] umask();
    return (m_uw == LW) ? '1 : ((LW'(1) << m_uw) - LW'(1));
  endfunction

  function automatic int slot(int k);
    return m_big ? (m_n - 1 - k) : k;
  endfunction

  task automatic check(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] act=%h exp=%h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    oq.delete(); iq.delete(); pend = 1'b0; pword = '0;
  endtask

  task automatic step(bit do_flush);
    logic          e_rd_valid, e_rd_ready, e_wr_ready, popped;
    logic [LW-1:0] e_rd_data, w;
    @(negedge clk_i);
    flush_ni        = !do_flush;
    fifo_rd_valid_i = ($urandom % 4) != 0;
    fifo_rd_data_i  = {$urandom, $urandom};
    port_rd_en_i    = ($urandom % 3) != 0;
    port_wr_en_i    = ($urandom % 3) != 0;
    port_wr_data_i  = {$urandom, $urandom};
    fifo_wr_ready_i = ($urandom % 4) != 0;
    // R11: pins wiggle after reset
    bus_match_i = $urandom; size_i = $urandom; big_end_i = $urandom;
    #1;
    e_rd_valid = oq.size() > 0;
    e_rd_data  = e_rd_valid ? oq[0] : '0;
    e_rd_ready = !e_rd_valid || (port_rd_en_i && oq.size() == 1);
    e_wr_ready = !pend || fifo_wr_ready_i;
    check("R5 R10 port_rd_valid", LW'(port_rd_valid_o), LW'(e_rd_valid));
    check("R2 R3 R4 port_rd_data", port_rd_data_o, e_rd_data);
    check("R5 fifo_rd_ready", LW'(fifo_rd_ready_o), LW'(e_rd_ready));
    check("R8 port_wr_ready", LW'(port_wr_ready_o), LW'(e_wr_ready));
    check("R8 fifo_wr_valid", LW'(fifo_wr_valid_o), LW'(pend));
    if (pend) check("R6 R7 R10 fifo_wr_data", fifo_wr_data_o, pword);
    if (do_flush) begin
      model_clear();
    end else begin
      if (e_rd_valid && port_rd_en_i) void'(oq.pop_front());
      if (fifo_rd_valid_i && e_rd_ready)
        for (int k = 0; k < m_n; k++)
          oq.push_back((fifo_rd_data_i >> (slot(k) * m_uw)) & umask());
      popped = pend && fifo_wr_ready_i;
      if (popped) pend = 1'b0;
      if (port_wr_en_i && e_wr_ready) begin
        iq.push_back(port_wr_data_i & umask());
        if (iq.size() == m_n) begin
          w = '0;
          for (int k = 0; k < m_n; k++) w |= iq[k] << (slot(k) * m_uw);
          iq.delete();
          pend = 1'b1;
          pword = w;
        end
      end
    end
  endtask

  task automatic do_reset(bit bm, bit sz, bit be);
    @(negedge clk_i);
    rst_ni = 1'b0; flush_ni = 1'b1;
    bus_match_i = bm; size_i = sz; big_end_i = be;
    fifo_rd_valid_i = 1'b0; port_rd_en_i = 1'b0; port_wr_en_i = 1'b0; fifo_wr_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    phase = "R4 R9 reset";
    check("R4 port_rd_data zero", port_rd_data_o, '0);
    check("R9 port_rd_valid low", LW'(port_rd_valid_o), '0);
    check("R9 fifo_wr_valid low", LW'(fifo_wr_valid_o), '0);
    rst_ni = 1'b1;
    m_n   = !bm ? 1 : (sz ? 4 : 2);
    m_uw  = LW / m_n;
    m_big = be;
    model_clear();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: every width in both orders (R2 R3 R6 R7)
    for (int cfg = 0; cfg < 6; cfg++) begin
      do_reset(cfg / 2 != 0, cfg / 2 == 2, cfg[0]);
      phase = "R1 R11 traffic";
      for (int c = 0; c < 400; c++) begin
        if (c % 97 == 50) begin
          phase = "R9 flush";
          step(1'b1);
          phase = "R1 R11 traffic";
        end else begin
          step(1'b0);
        end
      end
    end
    @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule